// File: doc/BRIEF.md
# Two-Way Translation Cache with Software Refill

This block turns 40-bit virtual addresses into 36-bit physical addresses. It keeps recent page translations in a two-way set-associative table with 256 sets. Each lookup is registered on entry and answered one cycle later. The answer is exactly one of four outcomes: a translation, a miss trap, a protection fault or a dirty-update trap.

The block never reads page tables in memory. When a lookup misses, supervisor software finds the mapping and writes it in through a table port, and that port accepts commands only in kernel mode. The same port removes entries and clears every reference bit at once. Each set keeps one recency bit, and an install that does not name a way uses that bit to choose its victim. A configuration input chooses how a first write to a clean page is handled: the hardware either sets the dirty bit itself or traps to software.

Top module: `vm_xlat_tlb`

## Requirements
- R1: The page offset is `req_vaddr[13:0]`, the set index is `req_vaddr[21:14]` and the tag is `req_vaddr[39:22]`. The table command takes its page number on `tbl_vpn`, with the set index in `tbl_vpn[7:0]` and the tag in `tbl_vpn[25:8]`. On a translation, `resp_paddr` is the stored 22-bit frame number followed by the 14-bit offset, passed through unchanged.
- R2: A request presented at clock edge N is answered with a one-cycle `resp_valid` pulse after edge N+1. No response appears without a request.
- R3: When no valid entry in the indexed set has a matching tag, `resp_miss` is 1 and `resp_paddr` is 0. Nothing in the table changes.
- R4: Table commands take effect only while `tbl_kernel` is 1. A command with `tbl_kernel` 0 changes nothing. `tbl_reject` is 1 for the one cycle after any command issued with `tbl_kernel` 0, and is 0 otherwise.
- R5: The rights codes are 00 (kernel only), 01 (read), 10 (read and write) and 11 (read, write and fetch). The `req_kind` codes are 00 read, 01 write, 10 fetch, and 11, which is handled as fetch. A kernel request to a code-00 page is always allowed. A matching entry whose rights forbid the access gives `resp_prot_fault` with `resp_paddr` 0.
- R6: Every tag match sets that entry's reference bit. `resp_ref` reports the bit's value before this lookup. Table op 10 clears every reference bit, and an install clears the bit of the entry it writes.
- R7: A permitted write that hits a clean entry gives `resp_dirty_trap` with `resp_paddr` 0 when `hw_dirty_en` is 0. When `hw_dirty_en` is 1, the access translates and the entry becomes dirty. An install with `tbl_dirty` 1 stores the entry as dirty.
- R8: Table op 00 installs an entry. `tbl_way` = 1x places it in way x. `tbl_way` = 0x picks the victim automatically: way 0 if it is invalid, else way 1 if it is invalid, else the least recently used way. Every translation and every install marks the way it used as most recent.
- R9: Table op 01 invalidates every way of the set whose tag matches `tbl_vpn`. Entries with other tags are left alone. Op 11 does nothing.
- R10: When both ways match, way 0 supplies the result and `resp_multi_hit` is 1.
- R11: Every response raises exactly one of `resp_hit`, `resp_miss`, `resp_prot_fault` and `resp_dirty_trap`. Outside a response all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 40 | Virtual address |
| req_kind | input | 2 | Access type: 00 read, 01 write, 10 or 11 fetch |
| req_kernel | input | 1 | Request made in kernel mode |
| hw_dirty_en | input | 1 | Hardware sets the dirty bit instead of trapping |
| tbl_valid | input | 1 | Table command strobe |
| tbl_kernel | input | 1 | Command issued in kernel mode |
| tbl_op | input | 2 | 00 install, 01 invalidate, 10 clear reference bits, 11 none |
| tbl_vpn | input | 26 | Virtual page number of the command |
| tbl_way | input | 2 | Bit 1 selects an explicit way, bit 0 is that way |
| tbl_ppn | input | 22 | Frame number to install |
| tbl_rights | input | 2 | Rights code to install |
| tbl_dirty | input | 1 | Dirty bit to install |
| resp_valid | output | 1 | Response pulse |
| resp_paddr | output | 36 | Physical address; 0 unless `resp_hit` |
| resp_hit | output | 1 | Translation delivered |
| resp_miss | output | 1 | Miss trap |
| resp_prot_fault | output | 1 | Protection fault |
| resp_dirty_trap | output | 1 | Dirty-update trap |
| resp_multi_hit | output | 1 | Both ways matched |
| resp_ref | output | 1 | Reference bit of the matched entry before this lookup |
| tbl_reject | output | 1 | Previous command was refused for lack of kernel mode |

## Verification
The assertions assume that no input is ever X or Z once reset ends. They also take for granted that a table command and a lookup never touch the same entry in the same cycle, because they check the offset and the dirty trap against the request of the previous cycle. The stimulus keeps within these limits: inputs change only on the falling clock edge, and every lookup and every table command runs to completion before the next one is issued.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W  = 40;
    parameter int PA_W  = 36;
    parameter int PG_W  = 14;
    parameter int SET_W = 8;

    localparam int VPN_W = VA_W - PG_W;
    localparam int TAG_W = VPN_W - SET_W;
    localparam int PPN_W = PA_W - PG_W;
    localparam int SETS  = 1 << SET_W;

    typedef enum logic [1:0] {
        ACC_READ      = 2'b00,
        ACC_WRITE     = 2'b01,
        ACC_FETCH     = 2'b10,
        ACC_FETCH_ALT = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        RGT_KERN = 2'b00,
        RGT_RO   = 2'b01,
        RGT_RW   = 2'b10,
        RGT_RWX  = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        TOP_FILL   = 2'b00,
        TOP_DROP   = 2'b01,
        TOP_REFCLR = 2'b10,
        TOP_NONE   = 2'b11
    } tblop_e;

    typedef struct packed {
        logic               valid;
        logic               dirty;
        rights_e            rights;
        logic [TAG_W-1:0]   tag;
        logic [PPN_W-1:0]   ppn;
    } entry_t;

    function automatic logic access_ok(input rights_e r, input acc_e k, input logic kern);
        logic ok;
        unique case (r)
            RGT_KERN: ok = kern;
            RGT_RO:   ok = (k == ACC_READ);
            RGT_RW:   ok = (k == ACC_READ) || (k == ACC_WRITE);
            default:  ok = 1'b1;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/tlb_way_array.sv
module tlb_way_array
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    output entry_t           rd_entry,
    output logic             rd_ref,
    input  logic [SET_W-1:0] probe_set,
    output logic             probe_valid,
    output logic [TAG_W-1:0] probe_tag,
    input  logic             fill_en,
    input  logic             kill_en,
    input  entry_t           fill_entry,
    input  logic             touch_en,
    input  logic             mark_dirty_en,
    input  logic             ref_clear
);
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [SETS-1:0]  ref_q;
    rights_e          rights_q [SETS];
    logic [TAG_W-1:0] tag_q    [SETS];
    logic [PPN_W-1:0] ppn_q    [SETS];

    always_comb begin
        rd_entry.valid  = valid_q[rd_set];
        rd_entry.dirty  = dirty_q[rd_set];
        rd_entry.rights = rights_q[rd_set];
        rd_entry.tag    = tag_q[rd_set];
        rd_entry.ppn    = ppn_q[rd_set];
        rd_ref          = ref_q[rd_set];
        probe_valid     = valid_q[probe_set];
        probe_tag       = tag_q[probe_set];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
            ref_q   <= '0;
        end else begin
            if (ref_clear)     ref_q <= '0;
            if (touch_en)      ref_q[rd_set] <= 1'b1;
            if (mark_dirty_en) dirty_q[rd_set] <= 1'b1;
            if (kill_en)       valid_q[probe_set] <= 1'b0;
            if (fill_en) begin
                valid_q[probe_set] <= 1'b1;
                dirty_q[probe_set] <= fill_entry.dirty;
                ref_q[probe_set]   <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            rights_q[probe_set] <= fill_entry.rights;
            tag_q[probe_set]    <= fill_entry.tag;
            ppn_q[probe_set]    <= fill_entry.ppn;
        end
    end
endmodule

// File: rtl/tlb_lru_bits.sv
module tlb_lru_bits
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_lru,
    input  logic             use_en,
    input  logic [SET_W-1:0] use_set,
    input  logic             use_way,
    input  logic             fill_en,
    input  logic             fill_way
);
    logic [SETS-1:0] lru_q;

    assign rd_lru = lru_q[rd_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else begin
            if (use_en)  lru_q[use_set] <= ~use_way;
            if (fill_en) lru_q[rd_set]  <= ~fill_way;
        end
    end
endmodule

// File: rtl/vm_xlat_tlb.sv
module vm_xlat_tlb
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_kernel,
    input  logic             hw_dirty_en,
    input  logic             tbl_valid,
    input  logic             tbl_kernel,
    input  logic [1:0]       tbl_op,
    input  logic [VPN_W-1:0] tbl_vpn,
    input  logic [1:0]       tbl_way,
    input  logic [PPN_W-1:0] tbl_ppn,
    input  logic [1:0]       tbl_rights,
    input  logic             tbl_dirty,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_hit,
    output logic             resp_miss,
    output logic             resp_prot_fault,
    output logic             resp_dirty_trap,
    output logic             resp_multi_hit,
    output logic             resp_ref,
    output logic             tbl_reject
);
    localparam int WAYS = 2;

    // request stage
    logic             rq_v, rq_kern, rq_hwd;
    acc_e             rq_kind;
    logic [SET_W-1:0] rq_set;
    logic [TAG_W-1:0] rq_tag;
    logic [PG_W-1:0]  rq_off;

    always_ff @(posedge clk) begin
        if (rst) rq_v <= 1'b0;
        else     rq_v <= req_valid;
    end

    always_ff @(posedge clk) begin
        if (req_valid) begin
            rq_off  <= req_vaddr[PG_W-1:0];
            rq_set  <= req_vaddr[PG_W+SET_W-1:PG_W];
            rq_tag  <= req_vaddr[VA_W-1:PG_W+SET_W];
            rq_kind <= acc_e'(req_kind);
            rq_kern <= req_kernel;
            rq_hwd  <= hw_dirty_en;
        end
    end

    // table command decode
    tblop_e           t_op;
    logic             t_priv;
    logic [SET_W-1:0] t_set;
    logic [TAG_W-1:0] t_tag;
    entry_t           t_entry;

    assign t_op   = tblop_e'(tbl_op);
    assign t_priv = tbl_valid && tbl_kernel;
    assign t_set  = tbl_vpn[SET_W-1:0];
    assign t_tag  = tbl_vpn[VPN_W-1:SET_W];

    always_comb begin
        t_entry.valid  = 1'b1;
        t_entry.dirty  = tbl_dirty;
        t_entry.rights = rights_e'(tbl_rights);
        t_entry.tag    = t_tag;
        t_entry.ppn    = tbl_ppn;
    end

    // way storage
    entry_t           rd_e     [WAYS];
    logic [WAYS-1:0]  rd_r;
    logic [WAYS-1:0]  pb_valid;
    logic [TAG_W-1:0] pb_tag   [WAYS];
    logic [WAYS-1:0]  match, fill_en, kill_en, touch_en, mark_en;
    logic             lru_rd, victim, sel_way, refclr;

    assign refclr = t_priv && (t_op == TOP_REFCLR);

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign match[w]   = rd_e[w].valid && (rd_e[w].tag == rq_tag);
            assign fill_en[w] = t_priv && (t_op == TOP_FILL) && (victim == 1'(w));
            assign kill_en[w] = t_priv && (t_op == TOP_DROP) && pb_valid[w] && (pb_tag[w] == t_tag);
            assign touch_en[w] = rq_v && match[w] && (sel_way == 1'(w));

            tlb_way_array u_way (
                .clk           (clk),
                .rst           (rst),
                .rd_set        (rq_set),
                .rd_entry      (rd_e[w]),
                .rd_ref        (rd_r[w]),
                .probe_set     (t_set),
                .probe_valid   (pb_valid[w]),
                .probe_tag     (pb_tag[w]),
                .fill_en       (fill_en[w]),
                .kill_en       (kill_en[w]),
                .fill_entry    (t_entry),
                .touch_en      (touch_en[w]),
                .mark_dirty_en (mark_en[w]),
                .ref_clear     (refclr)
            );
        end
    endgenerate

    // victim choice for installs
    always_comb begin
        if (tbl_way[1])        victim = tbl_way[0];
        else if (!pb_valid[0]) victim = 1'b0;
        else if (!pb_valid[1]) victim = 1'b1;
        else                   victim = lru_rd;
    end

    // lookup evaluation
    entry_t sel_e;
    logic   sel_ref, any_m, perm, need_dirty, lk_dtrap, lk_hit, lk_fault;

    always_comb begin
        sel_way    = !match[0];
        sel_e      = sel_way ? rd_e[1] : rd_e[0];
        sel_ref    = sel_way ? rd_r[1] : rd_r[0];
        any_m      = |match;
        perm       = access_ok(sel_e.rights, rq_kind, rq_kern);
        need_dirty = any_m && perm && (rq_kind == ACC_WRITE) && !sel_e.dirty;
        lk_dtrap   = need_dirty && !rq_hwd;
        lk_hit     = any_m && perm && !lk_dtrap;
        lk_fault   = any_m && !perm;
    end

    assign mark_en[0] = touch_en[0] && need_dirty && rq_hwd;
    assign mark_en[1] = touch_en[1] && need_dirty && rq_hwd;

    tlb_lru_bits u_lru (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (t_set),
        .rd_lru   (lru_rd),
        .use_en   (rq_v && lk_hit),
        .use_set  (rq_set),
        .use_way  (sel_way),
        .fill_en  (|fill_en),
        .fill_way (victim)
    );

    // response stage
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid      <= 1'b0;
            resp_paddr      <= '0;
            resp_hit        <= 1'b0;
            resp_miss       <= 1'b0;
            resp_prot_fault <= 1'b0;
            resp_dirty_trap <= 1'b0;
            resp_multi_hit  <= 1'b0;
            resp_ref        <= 1'b0;
            tbl_reject      <= 1'b0;
        end else begin
            resp_valid      <= rq_v;
            resp_paddr      <= (rq_v && lk_hit) ? {sel_e.ppn, rq_off} : '0;
            resp_hit        <= rq_v && lk_hit;
            resp_miss       <= rq_v && !any_m;
            resp_prot_fault <= rq_v && lk_fault;
            resp_dirty_trap <= rq_v && lk_dtrap;
            resp_multi_hit  <= rq_v && (&match);
            resp_ref        <= rq_v && any_m && sel_ref;
            tbl_reject      <= tbl_valid && !tbl_kernel;
        end
    end
endmodule

// File: rtl/vm_xlat_tlb_chk.sv
module vm_xlat_tlb_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic [1:0]       req_kind,
    input logic             hw_dirty_en,
    input logic             tbl_valid,
    input logic             tbl_kernel,
    input logic             resp_valid,
    input logic [PA_W-1:0]  resp_paddr,
    input logic             resp_hit,
    input logic             resp_miss,
    input logic             resp_prot_fault,
    input logic             resp_dirty_trap,
    input logic             resp_multi_hit,
    input logic             tbl_reject
);
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> resp_paddr[PG_W-1:0] == $past(req_vaddr[PG_W-1:0], 2));

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ##1 resp_valid);

    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ##1 !resp_valid);

    p_miss_no_xlat_r3: assert property (@(posedge clk) disable iff (rst)
        resp_miss |-> (resp_paddr == '0) && !resp_hit);

    p_user_cmd_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (tbl_valid && !tbl_kernel) |=> tbl_reject);

    p_kernel_cmd_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !(tbl_valid && !tbl_kernel) |=> !tbl_reject);

    p_fault_no_xlat_r5: assert property (@(posedge clk) disable iff (rst)
        resp_prot_fault |-> resp_paddr == '0);

    p_dtrap_on_write_r7: assert property (@(posedge clk) disable iff (rst)
        resp_dirty_trap |-> ($past(req_kind, 2) == ACC_WRITE) && !$past(hw_dirty_en, 2)
                             && (resp_paddr == '0));

    p_multi_not_miss_r10: assert property (@(posedge clk) disable iff (rst)
        resp_multi_hit |-> !resp_miss && resp_valid);

    p_one_outcome_r11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $countones({resp_hit, resp_miss, resp_prot_fault, resp_dirty_trap}) == 1);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> $countones({resp_hit, resp_miss, resp_prot_fault, resp_dirty_trap}) == 0);
endmodule

bind vm_xlat_tlb vm_xlat_tlb_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_vaddr       (req_vaddr),
    .req_kind        (req_kind),
    .hw_dirty_en     (hw_dirty_en),
    .tbl_valid       (tbl_valid),
    .tbl_kernel      (tbl_kernel),
    .resp_valid      (resp_valid),
    .resp_paddr      (resp_paddr),
    .resp_hit        (resp_hit),
    .resp_miss       (resp_miss),
    .resp_prot_fault (resp_prot_fault),
    .resp_dirty_trap (resp_dirty_trap),
    .resp_multi_hit  (resp_multi_hit),
    .tbl_reject      (tbl_reject)
);

// File: tb/vm_xlat_tlb_tb_top.sv
module vm_xlat_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [39:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_kernel = 1'b0;
    logic        hw_dirty_en = 1'b0;
    logic        tbl_valid = 1'b0;
    logic        tbl_kernel = 1'b0;
    logic [1:0]  tbl_op = 2'b11;
    logic [25:0] tbl_vpn = '0;
    logic [1:0]  tbl_way = '0;
    logic [21:0] tbl_ppn = '0;
    logic [1:0]  tbl_rights = '0;
    logic        tbl_dirty = 1'b0;
    logic        resp_valid, resp_hit, resp_miss, resp_prot_fault, resp_dirty_trap;
    logic        resp_multi_hit, resp_ref, tbl_reject;
    logic [35:0] resp_paddr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // sampled response
    logic [4:0]  s_flags;
    logic [35:0] s_pa;
    logic        s_multi, s_ref, s_rej;

    always #10 clk = ~clk;

    vm_xlat_tlb dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_kernel(req_kernel), .hw_dirty_en(hw_dirty_en),
        .tbl_valid(tbl_valid), .tbl_kernel(tbl_kernel), .tbl_op(tbl_op),
        .tbl_vpn(tbl_vpn), .tbl_way(tbl_way), .tbl_ppn(tbl_ppn),
        .tbl_rights(tbl_rights), .tbl_dirty(tbl_dirty),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_hit(resp_hit),
        .resp_miss(resp_miss), .resp_prot_fault(resp_prot_fault),
        .resp_dirty_trap(resp_dirty_trap), .resp_multi_hit(resp_multi_hit),
        .resp_ref(resp_ref), .tbl_reject(tbl_reject)
    );

    // flag vector: {valid, hit, miss, fault, dirty_trap}
    localparam logic [4:0] F_HIT  = 5'b11000;
    localparam logic [4:0] F_MISS = 5'b10100;
    localparam logic [4:0] F_FLT  = 5'b10010;
    localparam logic [4:0] F_DTR  = 5'b10001;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic lookup(input logic [39:0] va, input logic [1:0] k,
                          input logic kern, input logic hwd);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = k; req_kernel = kern; hw_dirty_en = hwd;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        s_flags = {resp_valid, resp_hit, resp_miss, resp_prot_fault, resp_dirty_trap};
        s_pa = resp_paddr; s_multi = resp_multi_hit; s_ref = resp_ref;
    endtask

    task automatic tcmd(input logic [1:0] op, input logic kern, input logic [25:0] vpn,
                        input logic [1:0] way, input logic [21:0] ppn,
                        input logic [1:0] rights, input logic dirty);
        @(negedge clk);
        tbl_valid = 1'b1; tbl_kernel = kern; tbl_op = op; tbl_vpn = vpn; tbl_way = way;
        tbl_ppn = ppn; tbl_rights = rights; tbl_dirty = dirty;
        @(negedge clk);
        tbl_valid = 1'b0;
        s_rej = tbl_reject;
    endtask

    function automatic logic [39:0] mkva(input logic [17:0] tg, input logic [7:0] st,
                                         input logic [13:0] off);
        return {tg, st, off};
    endfunction

    function automatic logic exp_ok(input int r, input int k, input logic kern);
        if (r == 0) return kern;
        if (r == 1) return k == 0;
        if (r == 2) return k <= 1;
        return 1'b1;
    endfunction

    task automatic expect_res(input string req, input logic [4:0] fl, input logic [35:0] pa);
        chk(req, {59'd0, s_flags}, {59'd0, fl});
        chk(req, {28'd0, s_pa}, {28'd0, pa});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // reset state (R2, R11)
        chk("R2 reset resp_valid", {63'd0, resp_valid}, 64'd0);
        chk("R4 reset tbl_reject", {63'd0, tbl_reject}, 64'd0);
        lookup(mkva(18'h1, 8'h5, 14'h10), 2'b00, 1'b1, 1'b0);
        expect_res("R3 miss after reset", F_MISS, 36'd0);

        // R1/R3: sweep all sets, one entry each, auto way
        for (int s = 0; s < 256; s++)
            tcmd(2'b00, 1'b1, {18'((s * 5 + 3)), 8'(s)}, 2'b00, 22'((s * 97 + 11)), 2'b11, 1'b1);
        for (int s = 0; s < 256; s++) begin
            logic [13:0] off;
            off = 14'((s * 61 + 7));
            lookup(mkva(18'((s * 5 + 3)), 8'(s), off), 2'b00, 1'b0, 1'b0);
            expect_res("R1 set sweep translate", F_HIT, {22'((s * 97 + 11)), off});
            if (s % 16 == 5) begin
                lookup(mkva(18'((s * 5 + 4)), 8'(s), off), 2'b00, 1'b0, 1'b0);
                expect_res("R3 wrong tag miss", F_MISS, 36'd0);
            end
        end

        // R5: rights x kind x privilege sweep
        do_reset();
        for (int r = 0; r < 4; r++)
            tcmd(2'b00, 1'b1, {18'(r + 40), 8'h33}, 2'b00, 22'(r * 1000 + 9), 2'(r), 1'b1);
        // two ways only: re-install per rights code before its sweep
        for (int r = 0; r < 4; r++) begin
            tcmd(2'b00, 1'b1, {18'(r + 40), 8'h33}, 2'b10, 22'(r * 1000 + 9), 2'(r), 1'b1);
            for (int k = 0; k < 4; k++)
                for (int kn = 0; kn < 2; kn++) begin
                    int ke;
                    ke = (k == 3) ? 2 : k;
                    lookup(mkva(18'(r + 40), 8'h33, 14'h2a5), 2'(k), 1'(kn), 1'b0);
                    if (exp_ok(r, ke, 1'(kn)))
                        expect_res("R5 rights allowed", F_HIT, {22'(r * 1000 + 9), 14'h2a5});
                    else
                        expect_res("R5 rights fault", F_FLT, 36'd0);
                end
        end

        // R4: user-mode commands ignored and flagged
        do_reset();
        tcmd(2'b00, 1'b0, {18'h77, 8'h10}, 2'b00, 22'h123, 2'b11, 1'b1);
        chk("R4 user install flagged", {63'd0, s_rej}, 64'd1);
        lookup(mkva(18'h77, 8'h10, 14'h0), 2'b00, 1'b1, 1'b0);
        expect_res("R4 user install ignored", F_MISS, 36'd0);
        tcmd(2'b00, 1'b1, {18'h77, 8'h10}, 2'b00, 22'h123, 2'b11, 1'b1);
        chk("R4 kernel install not flagged", {63'd0, s_rej}, 64'd0);
        tcmd(2'b01, 1'b0, {18'h77, 8'h10}, 2'b00, 22'h0, 2'b00, 1'b0);
        chk("R4 user invalidate flagged", {63'd0, s_rej}, 64'd1);
        lookup(mkva(18'h77, 8'h10, 14'h4), 2'b00, 1'b1, 1'b0);
        expect_res("R4 user invalidate ignored", F_HIT, {22'h123, 14'h4});

        // R6: reference bits
        chk("R6 first ref clear", {63'd0, s_ref}, 64'd0);
        lookup(mkva(18'h77, 8'h10, 14'h4), 2'b00, 1'b1, 1'b0);
        chk("R6 ref set after hit", {63'd0, s_ref}, 64'd1);
        tcmd(2'b10, 1'b0, 26'd0, 2'b00, 22'd0, 2'b00, 1'b0);
        lookup(mkva(18'h77, 8'h10, 14'h4), 2'b00, 1'b1, 1'b0);
        chk("R6 user clear ignored", {63'd0, s_ref}, 64'd1);
        tcmd(2'b10, 1'b1, 26'd0, 2'b00, 22'd0, 2'b00, 1'b0);
        lookup(mkva(18'h77, 8'h10, 14'h4), 2'b00, 1'b1, 1'b0);
        chk("R6 kernel clear", {63'd0, s_ref}, 64'd0);
        tcmd(2'b00, 1'b1, {18'h77, 8'h10}, 2'b10, 22'h124, 2'b11, 1'b1);
        lookup(mkva(18'h77, 8'h10, 14'h4), 2'b00, 1'b1, 1'b0);
        chk("R6 install clears ref", {63'd0, s_ref}, 64'd0);

        // R7: dirty handling
        tcmd(2'b00, 1'b1, {18'h5, 8'h20}, 2'b00, 22'h3c3, 2'b10, 1'b0);
        lookup(mkva(18'h5, 8'h20, 14'h11), 2'b00, 1'b0, 1'b0);
        expect_res("R7 read on clean page", F_HIT, {22'h3c3, 14'h11});
        lookup(mkva(18'h5, 8'h20, 14'h11), 2'b01, 1'b0, 1'b0);
        expect_res("R7 write on clean traps", F_DTR, 36'd0);
        lookup(mkva(18'h5, 8'h20, 14'h12), 2'b01, 1'b0, 1'b1);
        expect_res("R7 hw dirty write", F_HIT, {22'h3c3, 14'h12});
        lookup(mkva(18'h5, 8'h20, 14'h13), 2'b01, 1'b0, 1'b0);
        expect_res("R7 write after marked", F_HIT, {22'h3c3, 14'h13});
        tcmd(2'b00, 1'b1, {18'h6, 8'h21}, 2'b00, 22'h3c4, 2'b10, 1'b1);
        lookup(mkva(18'h6, 8'h21, 14'h1), 2'b01, 1'b0, 1'b0);
        expect_res("R7 installed dirty", F_HIT, {22'h3c4, 14'h1});

        // R8: victim choice
        do_reset();
        tcmd(2'b00, 1'b1, {18'hA, 8'h40}, 2'b00, 22'hA0, 2'b11, 1'b1);
        tcmd(2'b00, 1'b1, {18'hB, 8'h40}, 2'b00, 22'hB0, 2'b11, 1'b1);
        lookup(mkva(18'hA, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R8 A in set", F_HIT, {22'hA0, 14'h0});
        tcmd(2'b00, 1'b1, {18'hC, 8'h40}, 2'b00, 22'hC0, 2'b11, 1'b1);
        lookup(mkva(18'hB, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R8 B evicted as LRU", F_MISS, 36'd0);
        lookup(mkva(18'hA, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R8 A kept", F_HIT, {22'hA0, 14'h0});
        lookup(mkva(18'hC, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R8 C present", F_HIT, {22'hC0, 14'h0});
        tcmd(2'b00, 1'b1, {18'hD, 8'h40}, 2'b00, 22'hD0, 2'b11, 1'b1);
        lookup(mkva(18'hA, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R8 A evicted", F_MISS, 36'd0);
        lookup(mkva(18'hC, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R8 C kept", F_HIT, {22'hC0, 14'h0});
        lookup(mkva(18'hD, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R8 D present", F_HIT, {22'hD0, 14'h0});

        // R9: invalidate
        tcmd(2'b01, 1'b1, {18'hE, 8'h40}, 2'b00, 22'h0, 2'b00, 1'b0);
        lookup(mkva(18'hC, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R9 other tag untouched", F_HIT, {22'hC0, 14'h0});
        tcmd(2'b11, 1'b1, {18'hC, 8'h40}, 2'b00, 22'h0, 2'b00, 1'b0);
        lookup(mkva(18'hC, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R9 op 11 no effect", F_HIT, {22'hC0, 14'h0});
        tcmd(2'b01, 1'b1, {18'hC, 8'h40}, 2'b00, 22'h0, 2'b00, 1'b0);
        lookup(mkva(18'hC, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R9 invalidated", F_MISS, 36'd0);
        lookup(mkva(18'hD, 8'h40, 14'h0), 2'b00, 1'b0, 1'b0);
        expect_res("R9 neighbour kept", F_HIT, {22'hD0, 14'h0});

        // R10: multi-hit
        do_reset();
        tcmd(2'b00, 1'b1, {18'h9, 8'h7}, 2'b11, 22'h111, 2'b11, 1'b1);
        tcmd(2'b00, 1'b1, {18'h9, 8'h7}, 2'b10, 22'h222, 2'b11, 1'b1);
        lookup(mkva(18'h9, 8'h7, 14'h5), 2'b00, 1'b0, 1'b0);
        expect_res("R10 way 0 wins", F_HIT, {22'h222, 14'h5});
        chk("R10 multi flag", {63'd0, s_multi}, 64'd1);
        tcmd(2'b01, 1'b1, {18'h9, 8'h7}, 2'b00, 22'h0, 2'b00, 1'b0);
        lookup(mkva(18'h9, 8'h7, 14'h5), 2'b00, 1'b0, 1'b0);
        expect_res("R9 both ways invalidated", F_MISS, 36'd0);
        chk("R10 no multi on miss", {63'd0, s_multi}, 64'd0);

        // R11/R2: idle after response
        @(negedge clk);
        chk("R11 idle flags", {59'd0, resp_valid, resp_hit, resp_miss, resp_prot_fault,
            resp_dirty_trap}, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule